// File: doc/BRIEF.md
# Multi-Format Serial Transmitter

This block turns 9-bit words into asynchronous serial characters on one output line. Words are pushed into a 16-entry FIFO. A serializer takes them out one at a time and shifts each one out at one sixteenth of an external oversample tick rate. The character shape comes from three static controls:

- a 3-bit format code, which chooses data width, parity or a ninth data bit;
- a 2-bit stop-length code, which gives stop periods from half a bit to two bits;
- an odd/even parity select.

A run enable freezes the transmitter. An optional clear-to-send gate holds back new characters. A flush strobe throws away every word that has not started. Three FIFO level flags let the surrounding logic pace its writes.

Timing is counted in oversample ticks. Each bit of a character lasts 16 ticks. Characters start only on a tick.

Top module: `mfu_uart_tx`

## Requirements
- R1: After reset the line is high, fifo_empty=1, fifo_half_empty=1 and fifo_full=0.
- R2: A character is a low start bit held for 16 ticks, then the payload bits, least significant first, each held for 16 ticks. The line is high whenever no character is in progress. A character begins only on a tick.
- R3: The format code selects the payload:
  - 001 sends word bits 7:0.
  - 011 sends bits 6:0 followed by a parity bit.
  - 100 sends bits 8:0.
  - 101 sends bits 7:0 followed by word bit 8 as the wake-up bit.
  - 111 sends bits 7:0 followed by a parity bit.
  - Any other code sends as 001 does.
- R4: The parity bit makes the number of ones over the data bits and the parity bit odd when odd_par=1, and even when odd_par=0.
- R5: After the payload the line stays high for the stop period. The stop codes 00, 01, 10 and 11 give 8, 16, 24 and 32 ticks. When words are waiting, the next start bit begins exactly when the stop period ends, so starts are 16*(payload bits+1)+stop ticks apart.
- R6: fifo_empty is 1 when the FIFO holds 0 words. fifo_half_empty is 1 when it holds at most 8 words. fifo_full is 1 when it holds 16 words. The flags show a write on the cycle after it.
- R7: A write while fifo_full=1 is dropped. The stored words and the FIFO level do not change.
- R8: A fifo_flush pulse empties the FIFO on the next cycle, and the flushed words are never sent. A character already started is completed.
- R9: When cts_en=1 and cts_n=1 at a character boundary, no new character starts. A character already started is always completed.
- R10: While run=0 ticks are ignored: no character starts and the line level holds.
- R11: Words are sent in the order they were written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle oversample pulse, 16 per bit |
| run | input | 1 | Transmitter enable; when low, ticks are ignored |
| wr_en | input | 1 | Push wr_data into the FIFO |
| wr_data | input | 9 | Word to transmit |
| fmt | input | 3 | Character format code |
| stop_sel | input | 2 | Stop length code |
| odd_par | input | 1 | 1 = odd parity, 0 = even parity |
| cts_en | input | 1 | Enable clear-to-send gating |
| cts_n | input | 1 | Clear-to-send, active low, synchronous to clk |
| fifo_flush | input | 1 | Discard all words in the FIFO |
| txd | output | 1 | Serial line, idles high |
| fifo_empty | output | 1 | FIFO holds no words |
| fifo_half_empty | output | 1 | FIFO holds 8 words or fewer |
| fifo_full | output | 1 | FIFO holds 16 words |

## Verification
The assertions assume that tick is a single-cycle pulse and that cts_n is already synchronous to clk. They also assume that fmt, stop_sel and odd_par stay fixed while a character is on the line.

The stimulus keeps to these assumptions:
- It changes the format controls only while run is low and the line is idle.
- It produces tick from a free-running divider.
- It drives every control half a cycle away from the sampling edge.
- It toggles cts_n only at points where the expected outcome is unambiguous: mid-character, or with the line idle.

// File: rtl/mfu_tx_pkg.sv
package mfu_tx_pkg;

  localparam int WORD_W  = 9;
  localparam int FRAME_W = WORD_W + 1;

  localparam logic [2:0] FMT_D8  = 3'b001;
  localparam logic [2:0] FMT_D7P = 3'b011;
  localparam logic [2:0] FMT_D9  = 3'b100;
  localparam logic [2:0] FMT_D8W = 3'b101;
  localparam logic [2:0] FMT_D8P = 3'b111;

  // number of bits following the start bit
  function automatic logic [3:0] payload_len(input logic [2:0] fmt);
    case (fmt)
      FMT_D9, FMT_D8W, FMT_D8P: return 4'd9;
      default:                  return 4'd8;
    endcase
  endfunction

  // payload bits, LSB first on the line
  function automatic logic [WORD_W-1:0] payload_bits(input logic [2:0] fmt,
                                                     input logic [WORD_W-1:0] w,
                                                     input logic odd);
    logic [WORD_W-1:0] r;
    case (fmt)
      FMT_D7P:         r = {1'b0, (odd ? ~(^w[6:0]) : (^w[6:0])), w[6:0]};
      FMT_D8P:         r = {(odd ? ~(^w[7:0]) : (^w[7:0])), w[7:0]};
      FMT_D9, FMT_D8W: r = w;
      default:         r = {1'b0, w[7:0]};
    endcase
    return r;
  endfunction

  // stop period in oversample ticks: half-bit steps
  function automatic int stop_ticks(input logic [1:0] sel, input int tpb);
    return (int'(sel) + 1) * (tpb / 2);
  endfunction

endpackage

// File: rtl/mfu_tx_fifo.sv
module mfu_tx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         flush,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         half_empty,
  output logic         full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          accept, take;

  assign accept = push && !full && !flush;
  assign take   = pop && !empty && !flush;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (accept) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (take)   rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      cnt <= cnt + CW'(accept) - CW'(take);
    end
  end

  always_ff @(posedge clk) begin
    if (accept) mem[wp] <= wdata;
  end

  assign rdata      = mem[rp];
  assign empty      = (cnt == '0);
  assign full       = (cnt == CW'(DEPTH));
  assign half_empty = (cnt <= CW'(DEPTH / 2));

endmodule

// File: rtl/mfu_tx_shifter.sv
module mfu_tx_shifter
  import mfu_tx_pkg::*;
#(
  parameter int TPB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              cts_block,
  input  logic              have_data,
  input  logic [WORD_W-1:0] word,
  input  logic [2:0]        fmt,
  input  logic [1:0]        stop_sel,
  input  logic              odd,
  output logic              load,
  output logic              busy,
  output logic              txd
);
  localparam int TW = $clog2(TPB);
  localparam int SW = $clog2(2 * TPB + 1);

  typedef enum logic [1:0] {S_IDLE, S_BITS, S_STOP} st_t;

  st_t                st;
  logic [FRAME_W-1:0] shreg;
  logic [TW-1:0]      tcnt;
  logic [3:0]         bits_left;
  logic [SW-1:0]      stop_left;
  logic               tk, boundary;

  assign tk       = tick && run;
  assign boundary = (st == S_IDLE) || (st == S_STOP && stop_left == SW'(1));
  assign load     = tk && boundary && have_data && !cts_block;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      shreg     <= '1;
      tcnt      <= '0;
      bits_left <= '0;
      stop_left <= '0;
    end else if (load) begin
      shreg     <= {payload_bits(fmt, word, odd), 1'b0};
      bits_left <= payload_len(fmt) + 4'd1;
      tcnt      <= '0;
      st        <= S_BITS;
    end else if (tk) begin
      unique case (st)
        S_BITS: begin
          if (tcnt == TW'(TPB - 1)) begin
            tcnt      <= '0;
            shreg     <= {1'b1, shreg[FRAME_W-1:1]};
            bits_left <= bits_left - 4'd1;
            if (bits_left == 4'd1) begin
              st        <= S_STOP;
              stop_left <= SW'(stop_ticks(stop_sel, TPB));
            end
          end else begin
            tcnt <= tcnt + 1'b1;
          end
        end
        S_STOP: begin
          if (stop_left == SW'(1)) st <= S_IDLE;
          else stop_left <= stop_left - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);
  assign txd  = (st == S_BITS) ? shreg[0] : 1'b1;

endmodule

// File: rtl/mfu_uart_tx.sv
module mfu_uart_tx
  import mfu_tx_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int TPB   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              run,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [2:0]        fmt,
  input  logic [1:0]        stop_sel,
  input  logic              odd_par,
  input  logic              cts_en,
  input  logic              cts_n,
  input  logic              fifo_flush,
  output logic              txd,
  output logic              fifo_empty,
  output logic              fifo_half_empty,
  output logic              fifo_full
);
  logic [WORD_W-1:0] head;
  logic              load_evt;
  logic              busy;
  logic              cts_block;

  assign cts_block = cts_en && cts_n;

  mfu_tx_fifo #(.DEPTH(DEPTH), .W(WORD_W)) u_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .flush      (fifo_flush),
    .push       (wr_en),
    .pop        (load_evt),
    .wdata      (wr_data),
    .rdata      (head),
    .empty      (fifo_empty),
    .half_empty (fifo_half_empty),
    .full       (fifo_full)
  );

  mfu_tx_shifter #(.TPB(TPB)) u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .run       (run),
    .cts_block (cts_block),
    .have_data (!fifo_empty && !fifo_flush),
    .word      (head),
    .fmt       (fmt),
    .stop_sel  (stop_sel),
    .odd       (odd_par),
    .load      (load_evt),
    .busy      (busy),
    .txd       (txd)
  );

endmodule

// File: rtl/mfu_uart_tx_checker.sv
module mfu_uart_tx_checker (
  input logic clk,
  input logic rst_n,
  input logic run,
  input logic wr_en,
  input logic fifo_flush,
  input logic cts_en,
  input logic cts_n,
  input logic txd,
  input logic fifo_empty,
  input logic fifo_full,
  input logic busy,
  input logic load_evt
);

  // R2: idle line is high; a started character drives a low start bit
  assert_idle_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd);
  assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> !txd);

  // R6: a character start needs a stored word
  assert_start_needs_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !fifo_empty);

  // R7: a write into a full FIFO without a pop leaves it full
  assert_full_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && fifo_full && !load_evt && !fifo_flush) |=> fifo_full);

  // R8: a flush empties the FIFO on the next cycle
  assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_flush |=> fifo_empty);

  // R9: an idle transmitter stays idle while clear-to-send is withheld
  assert_cts_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && cts_en && cts_n) |=> !busy);

  // R10: with run low the line does not move
  assert_run_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(txd));

endmodule

bind mfu_uart_tx mfu_uart_tx_checker u_mfu_uart_tx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .wr_en      (wr_en),
  .fifo_flush (fifo_flush),
  .cts_en     (cts_en),
  .cts_n      (cts_n),
  .txd        (txd),
  .fifo_empty (fifo_empty),
  .fifo_full  (fifo_full),
  .busy       (busy),
  .load_evt   (load_evt)
);

// File: tb/mfu_uart_tx_bench.sv
module mfu_uart_tx_bench;
  localparam int DEPTH = 16;
  localparam int TPB   = 16;
  localparam int TDIV  = 4;

  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, run = 1'b0, wr_en = 1'b0;
  logic fifo_flush = 1'b0, cts_en = 1'b0, cts_n = 1'b0, odd_par = 1'b0;
  logic [8:0] wr_data = '0;
  logic [2:0] fmt = 3'b001;
  logic [1:0] stop_sel = 2'b01;
  logic txd, fifo_empty, fifo_half_empty, fifo_full;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  mfu_uart_tx #(.DEPTH(DEPTH), .TPB(TPB)) u_mfu_uart_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .wr_en(wr_en),
    .wr_data(wr_data), .fmt(fmt), .stop_sel(stop_sel), .odd_par(odd_par),
    .cts_en(cts_en), .cts_n(cts_n), .fifo_flush(fifo_flush), .txd(txd),
    .fifo_empty(fifo_empty), .fifo_half_empty(fifo_half_empty), .fifo_full(fifo_full)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int f_len(input logic [2:0] m);
    if (m == 3'b100 || m == 3'b101 || m == 3'b111) return 9;
    return 8;
  endfunction

  function automatic int f_stop(input logic [1:0] s);
    return 8 * (int'(s) + 1);
  endfunction

  function automatic logic [8:0] f_expect(input logic [2:0] m, input logic [8:0] w, input logic o);
    logic p;
    case (m)
      3'b011: begin p = (^w[6:0]) ^ o; return {1'b0, p, w[6:0]}; end
      3'b111: begin p = (^w[7:0]) ^ o; return {p, w[7:0]}; end
      3'b100, 3'b101: return w;
      default: return {1'b0, w[7:0]};
    endcase
  endfunction

  // line monitor: tick divider plus frame decoder, all at the falling edge
  int tidx = 0, phase = 0, mstart = 0, rx_n = 0, divc = 0;
  bit mact = 0, run_q = 0;
  logic [8:0] mword = '0;
  logic [8:0] rx_w [128];
  int rx_t [128];

  always @(negedge clk) begin
    int nb, st;
    nb = f_len(fmt);
    st = f_stop(stop_sel);
    if (!rst_n) begin
      mact = 0;
    end else if (tick && run_q) begin
      tidx++;
      if (!mact) begin
        if (txd == 1'b0) begin
          mact = 1; phase = 0; mstart = tidx; mword = '0;
        end
      end else begin
        phase++;
        if (phase == TPB / 2) chk(txd == 1'b0, "R2 start bit level", txd, 0);
        else if (phase % TPB == TPB / 2 && phase / TPB <= nb) mword[phase / TPB - 1] = txd;
        if (phase == TPB * (nb + 1) + st / 2) chk(txd == 1'b1, "R5 stop level", txd, 1);
        if (phase == TPB * (nb + 1) + st - 1) begin
          if (rx_n < 128) begin rx_w[rx_n] = mword; rx_t[rx_n] = mstart; end
          rx_n++;
          mact = 0;
        end
      end
    end
    run_q = run;
    divc = (divc + 1) % TDIV;
    tick <= (divc == 0);
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic wr(input logic [8:0] w); step(); wr_en = 1'b1; wr_data = w; step(); wr_en = 1'b0; endtask
  task automatic wait_ticks(input int n); repeat (n * TDIV) step(); endtask
  task automatic wait_rx(input int target, input string tag);
    int g = 0;
    while (rx_n < target && g < 60000) begin step(); g++; end
    chk(rx_n >= target, tag, rx_n, target);
  endtask
  task automatic pulse_flush(); step(); fifo_flush = 1'b1; step(); fifo_flush = 1'b0; endtask

  task automatic batch(input logic [2:0] m, input logic [1:0] s, input logic o, input int cnt);
    logic [8:0] sent [8];
    int base;
    run = 1'b0; fmt = m; stop_sel = s; odd_par = o;
    step();
    base = rx_n;
    for (int i = 0; i < cnt; i++) begin sent[i] = 9'($urandom); wr(sent[i]); end
    run = 1'b1;
    wait_rx(base + cnt, "R3 frames arrive");
    for (int i = 0; i < cnt; i++) begin
      logic [8:0] e;
      e = f_expect(m, sent[i], o);
      chk(rx_w[base + i] == e, $sformatf("R3 R4 fmt %b odd %0d payload", m, o), rx_w[base + i], e);
      if (i > 0)
        chk(rx_t[base + i] - rx_t[base + i - 1] == TPB * (f_len(m) + 1) + f_stop(s),
            $sformatf("R5 start spacing stop %b", s),
            rx_t[base + i] - rx_t[base + i - 1], TPB * (f_len(m) + 1) + f_stop(s));
    end
    wait_ticks(40);
    run = 1'b0;
  endtask

  logic [8:0] fill [DEPTH + 1];
  logic [2:0] fmt_list [5] = '{3'b001, 3'b011, 3'b100, 3'b101, 3'b111};

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    int base;
    void'($urandom(32'd1357));
    repeat (5) step();
    rst_n = 1'b1;
    step(); step();
    chk({txd, fifo_empty, fifo_half_empty, fifo_full} == 4'b1110, "R1 reset state",
        {txd, fifo_empty, fifo_half_empty, fifo_full}, 4'b1110);

    // R6 R7 R11: fill past full with run low, then drain
    fmt = 3'b001; stop_sel = 2'b01; odd_par = 1'b0;
    base = rx_n;
    for (int i = 0; i < DEPTH + 1; i++) begin
      int c;
      fill[i] = 9'(i * 37 + 5);
      wr(fill[i]);
      c = (i + 1 > DEPTH) ? DEPTH : i + 1;
      chk({fifo_empty, fifo_half_empty, fifo_full} == {c == 0, c <= DEPTH / 2, c == DEPTH},
          "R6 level flags", {fifo_empty, fifo_half_empty, fifo_full},
          {c == 0, c <= DEPTH / 2, c == DEPTH});
    end
    run = 1'b1;
    wait_rx(base + DEPTH, "R11 drain arrives");
    wait_ticks(400);
    chk(rx_n == base + DEPTH, "R7 dropped word not sent", rx_n - base, DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk(rx_w[base + i] == {1'b0, fill[i][7:0]}, "R11 order", rx_w[base + i], {1'b0, fill[i][7:0]});
      if (i > 0) chk(rx_t[base + i] - rx_t[base + i - 1] == 160, "R5 back-to-back spacing",
                     rx_t[base + i] - rx_t[base + i - 1], 160);
    end
    chk(fifo_empty == 1'b1, "R6 empty after drain", fifo_empty, 1);
    run = 1'b0;

    // directed format and stop coverage, then random formats
    for (int k = 0; k < 5; k++) batch(fmt_list[k], 2'(k % 4), 1'(k % 2), 4);
    batch(3'b011, 2'b00, 1'b1, 3);
    batch(3'b111, 2'b10, 1'b0, 3);
    for (int k = 0; k < 6; k++) batch(3'($urandom), 2'($urandom), 1'($urandom), 4);

    // R10: run low blocks start
    fmt = 3'b001; stop_sel = 2'b01; odd_par = 1'b0; run = 1'b0;
    base = rx_n;
    wr(9'h0A5);
    wait_ticks(300);
    chk(rx_n == base, "R10 no frame while stopped", rx_n - base, 0);
    chk(txd == 1'b1, "R10 line held", txd, 1);
    chk(fifo_empty == 1'b0, "R10 word retained", fifo_empty, 0);
    run = 1'b1;
    wait_rx(base + 1, "R10 frame after run");
    chk(rx_w[base] == 9'h0A5, "R10 word", rx_w[base], 9'h0A5);
    wait_ticks(40);

    // R8: flush of waiting words
    run = 1'b0;
    base = rx_n;
    for (int i = 0; i < 5; i++) wr(9'(i + 3));
    pulse_flush();
    chk(fifo_empty == 1'b1, "R8 flush empties", fifo_empty, 1);
    run = 1'b1;
    wait_ticks(400);
    chk(rx_n == base, "R8 flushed words not sent", rx_n - base, 0);
    chk(txd == 1'b1, "R8 line idle", txd, 1);

    // R8: flush while a character is on the line
    run = 1'b0;
    wr(9'h03C); wr(9'h0C3); wr(9'h055);
    run = 1'b1;
    while (!mact) step();
    pulse_flush();
    wait_ticks(600);
    chk(rx_n == base + 1, "R8 in-flight completes alone", rx_n - base, 1);
    chk(rx_w[base] == 9'h03C, "R8 in-flight word", rx_w[base], 9'h03C);

    // R9: clear-to-send gating
    base = rx_n;
    cts_en = 1'b1; cts_n = 1'b1;
    wr(9'h071);
    wait_ticks(400);
    chk(rx_n == base, "R9 held while not clear", rx_n - base, 0);
    chk(fifo_empty == 1'b0, "R9 word waiting", fifo_empty, 0);
    chk(txd == 1'b1, "R9 line high while held", txd, 1);
    cts_n = 1'b0;
    wait_rx(base + 1, "R9 release");
    chk(rx_w[base] == 9'h071, "R9 released word", rx_w[base], 9'h071);
    wait_ticks(40);
    run = 1'b0;
    wr(9'h01E); wr(9'h0E1);
    run = 1'b1;
    while (!mact) step();
    cts_n = 1'b1;
    wait_ticks(600);
    chk(rx_n == base + 2, "R9 started char completes", rx_n - base, 2);
    chk(rx_w[base + 1] == 9'h01E, "R9 completed word", rx_w[base + 1], 9'h01E);
    chk(fifo_empty == 1'b0, "R9 second word held", fifo_empty, 0);
    cts_n = 1'b0;
    wait_rx(base + 3, "R9 second release");
    chk(rx_w[base + 2] == 9'h0E1, "R9 second word", rx_w[base + 2], 9'h0E1);
    cts_en = 1'b0;
    wait_ticks(40);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule